// File: doc/BRIEF.md
# Dual-Lane Phase-Continuous MSK Tone Generator

This block synthesises a digital minimum-shift-keying waveform for a converter that accepts two samples per clock and converts them at twice the clock rate. The block therefore runs at half the output sample rate. On every clock it emits an even sample and an odd sample, which are two consecutive points of the same sine wave. Each point is looked up in its own copy of a one-cycle sine table.

One phase register holds the even-sample phase. The odd sample is read at that phase plus the active frequency word. The phase register advances by twice the active word on every clock. The integrator presents two candidate frequency words on ports. A symbol strobe, together with the data bit that comes with it, picks which word becomes active. The phase register is never cleared when the word changes, so the carrier stays continuous across bit boundaries. Both samples pass through one output register, and a valid flag marks the cycles in which that register holds a real table read.

Top module: `msk_dds_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `sampleValid`=0 and `evenSample`=`oddSample`=0. The phase becomes 0, and the active word is loaded from `wordZero`.
- R2: At the first edge with `rst` low, the table read of phase 0 completes. After that edge, `sampleValid`=1, `evenSample`=sin(0)=0 and `oddSample`=sin(wordZero).
- R3: At every edge out of reset, the 12-bit phase advances by twice the active word, modulo 4096, with the carry dropped. A word of 0 therefore holds the phase.
- R4: The odd sample is read at (phase + active word) mod 4096, while the even sample is read at the phase itself. With a word of 2048 the two samples are exact negatives of each other.
- R5: A sample for phase a is the 12-bit two's-complement value round(2047*sin(2*pi*a/4096)), rounded half away from zero. The value -2048 never appears.
- R6: When `symStb` is high at an edge, the active word becomes `wordOne` if `symBit`=1 and `wordZero` if `symBit`=0. The new word first affects the samples that appear after the following edge.
- R7: A change on `wordZero` or `wordOne` without a strobe has no effect on the samples.
- R8: Switching words does not reset or jump the phase. The phase keeps accumulating from its current value.
- R9: Samples appear one clock after the phase they were read at. `sampleValid` stays high on every cycle after the first read until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at half the output sample rate |
| rst | input | 1 | Synchronous active-high reset |
| symStb | input | 1 | Symbol strobe; loads a new active word |
| symBit | input | 1 | Data bit with the strobe; 1 picks `wordOne` |
| wordZero | input | 12 | Frequency word for bit 0 |
| wordOne | input | 12 | Frequency word for bit 1 |
| evenSample | output | 12 | First sample of the pair, signed |
| oddSample | output | 12 | Second sample of the pair, signed |
| sampleValid | output | 1 | Output register holds a table read |

## Verification
The hardest case to reach from the ports is a word port that changes while no strobe arrives. In that case the odd-sample offset and the phase step must both keep using the latched word. The stimulus rewrites `wordZero` in the middle of a symbol. The reference model keeps the earlier word, so any design that reads the port directly produces a different sample stream. The bench also reaches phase wrap with a large word, the half-rate word 2048, and a zero word, and then runs a long stretch of random strobes and words.

// File: rtl/msk_dds_pkg.sv
package msk_dds_pkg;
  // strobes handed from control to datapath
  typedef struct packed {
    logic loadWord;  // latch a new active frequency word
    logic pickOne;   // 1: take wordOne, 0: take wordZero
  } dds_ctrl_t;
endpackage

// File: rtl/msk_dds_ctrl.sv
module msk_dds_ctrl
  import msk_dds_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      symStb,
  input  logic      symBit,
  output dds_ctrl_t ctrl,
  output logic      validOut
);
  logic validQ;

  always_comb begin
    ctrl.loadWord = symStb;
    ctrl.pickOne  = symBit;
  end

  // the first post-reset edge completes the read of phase 0
  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b0;
    else     validQ <= 1'b1;
  end

  assign validOut = validQ;

  // once out of reset, the output register stays valid
  p_valid_hold_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> validOut);
endmodule

// File: rtl/msk_sine_lane.sv
module msk_sine_lane #(
  parameter int PHASE_W  = 12,
  parameter int SAMPLE_W = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [PHASE_W-1:0]         addr,
  output logic signed [SAMPLE_W-1:0] sampleOut
);
  localparam int QTR = 2 ** (PHASE_W - 2);
  localparam int AMP = 2 ** (SAMPLE_W - 1) - 1;
  localparam logic [PHASE_W-2:0] QTR_V = QTR[PHASE_W-2:0];
  localparam logic signed [SAMPLE_W-1:0] MIN_V = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam real TWO_PI = 6.283185307179586;

  // quarter wave, endpoints included: sin over [0, pi/2]
  logic signed [SAMPLE_W-1:0] quarterTab [0:QTR];

  initial begin
    for (int i = 0; i <= QTR; i++) begin
      real v;
      v = real'(AMP) * $sin(TWO_PI * real'(i) / real'(4 * QTR));
      quarterTab[i] = SAMPLE_W'($rtoi(v + 0.5));
    end
  end

  logic [1:0]                 quad;
  logic [PHASE_W-3:0]         idx;
  logic [PHASE_W-2:0]         tabIdx;
  logic signed [SAMPLE_W-1:0] mag;
  logic signed [SAMPLE_W-1:0] val;

  always_comb begin
    quad   = addr[PHASE_W-1:PHASE_W-2];
    idx    = addr[PHASE_W-3:0];
    tabIdx = quad[0] ? (QTR_V - {1'b0, idx}) : {1'b0, idx};
    mag    = quarterTab[tabIdx];
    val    = quad[1] ? -mag : mag;
  end

  always_ff @(posedge clk) begin
    if (rst) sampleOut <= '0;
    else     sampleOut <= val;
  end

  // symmetric table never yields the most negative code
  p_no_min_code_r5: assert property (@(posedge clk) disable iff (rst)
    sampleOut != MIN_V);
endmodule

// File: rtl/msk_dds_path.sv
module msk_dds_path
  import msk_dds_pkg::*;
#(
  parameter int PHASE_W  = 12,
  parameter int SAMPLE_W = 12,
  parameter int LANES    = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  dds_ctrl_t                  ctrl,
  input  logic [PHASE_W-1:0]         wordZero,
  input  logic [PHASE_W-1:0]         wordOne,
  output logic signed [SAMPLE_W-1:0] laneOut [LANES]
);
  localparam logic [PHASE_W-1:0] HALF_V = {1'b1, {(PHASE_W-1){1'b0}}};

  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] activeWord;
  logic [PHASE_W-1:0] stepVal;
  logic [PHASE_W-1:0] laneAddr [LANES];

  // lanes step LANES words per clock; carry out is dropped
  always_comb stepVal = PHASE_W'(LANES) * activeWord;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= '0;
      activeWord <= wordZero;
    end else begin
      phase <= phase + stepVal;
      if (ctrl.loadWord)
        activeWord <= ctrl.pickOne ? wordOne : wordZero;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_comb laneAddr[g] = phase + PHASE_W'(g) * activeWord;
    msk_sine_lane #(.PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W)) uLane (
      .clk      (clk),
      .rst      (rst),
      .addr     (laneAddr[g]),
      .sampleOut(laneOut[g])
    );
  end

  // word ports are ignored between strobes
  p_word_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !ctrl.loadWord |=> $stable(activeWord));
  // zero word freezes the phase
  p_zero_word_r3: assert property (@(posedge clk) disable iff (rst)
    (activeWord == '0) |=> (phase == $past(phase)));
  // half-turn offset gives antiphase samples
  p_half_turn_r4: assert property (@(posedge clk) disable iff (rst)
    (activeWord == HALF_V) |=> (laneOut[0] == -laneOut[1]));
endmodule

// File: rtl/msk_dds_gen.sv
module msk_dds_gen
  import msk_dds_pkg::*;
#(
  parameter int PHASE_W  = 12,
  parameter int SAMPLE_W = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       symStb,
  input  logic                       symBit,
  input  logic [PHASE_W-1:0]         wordZero,
  input  logic [PHASE_W-1:0]         wordOne,
  output logic signed [SAMPLE_W-1:0] evenSample,
  output logic signed [SAMPLE_W-1:0] oddSample,
  output logic                       sampleValid
);
  localparam int LANES = 2;

  dds_ctrl_t                  ctrlBus;
  logic signed [SAMPLE_W-1:0] lanes [LANES];

  msk_dds_ctrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .symStb  (symStb),
    .symBit  (symBit),
    .ctrl    (ctrlBus),
    .validOut(sampleValid)
  );

  msk_dds_path #(.PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W), .LANES(LANES)) uPath (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrlBus),
    .wordZero(wordZero),
    .wordOne (wordOne),
    .laneOut (lanes)
  );

  assign evenSample = lanes[0];
  assign oddSample  = lanes[1];
endmodule

// File: tb/msk_dds_gen_test.sv
module msk_dds_gen_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic symStb = 1'b0;
  logic symBit = 1'b0;
  logic [11:0] wordZero = 12'd1024;
  logic [11:0] wordOne  = 12'd512;
  logic signed [11:0] evenSample, oddSample;
  logic sampleValid;

  msk_dds_gen uut (
    .clk(clk), .rst(rst), .symStb(symStb), .symBit(symBit),
    .wordZero(wordZero), .wordOne(wordOne),
    .evenSample(evenSample), .oddSample(oddSample), .sampleValid(sampleValid)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit armed = 0;
  string curTag = "R1";

  // reference model state
  int mPhase, mWord, expEven, expOdd, expValid;

  function automatic int sinRef(int a);
    real v;
    v = 2047.0 * $sin(6.283185307179586 * real'(a % 4096) / 4096.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    armed = 1;
    if (rst) begin
      mPhase = 0; mWord = int'(wordZero);
      expEven = 0; expOdd = 0; expValid = 0;
    end else begin
      expEven  = sinRef(mPhase);
      expOdd   = sinRef(mPhase + mWord);
      expValid = 1;
      mPhase   = (mPhase + 2 * mWord) % 4096;
      if (symStb) mWord = symBit ? int'(wordOne) : int'(wordZero);
    end
  end

  always @(negedge clk) begin
    if (armed && !finished) begin
      chk(curTag, "valid", int'(sampleValid), expValid);
      chk(curTag, "even", int'(evenSample), expEven);
      chk(curTag, "odd", int'(oddSample), expOdd);
    end
  end

  task automatic runCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(bit b);
    symStb = 1'b1; symBit = b;
    @(negedge clk);
    symStb = 1'b0;
  endtask

  initial begin
    runCycles(3);
    // R1: reset state at the ports
    chk("R1", "reset valid", int'(sampleValid), 0);
    chk("R1", "reset even", int'(evenSample), 0);
    chk("R1", "reset odd", int'(oddSample), 0);
    rst = 1'b0;
    curTag = "R2";
    @(negedge clk);
    // R2: first read, phase 0 and wordZero=1024
    chk("R2", "first even", int'(evenSample), 0);
    chk("R2", "first odd", int'(oddSample), 2047);
    chk("R9", "first valid", int'(sampleValid), 1);
    curTag = "R5";
    @(negedge clk);
    // R5: phase 2048 and 3072
    chk("R5", "half-turn even", int'(evenSample), 0);
    chk("R5", "three-quarter odd", int'(oddSample), -2047);
    curTag = "R3"; runCycles(8);
    // R7: port change without strobe
    curTag = "R7"; wordZero = 12'd100; runCycles(6);
    wordOne = 12'd77; runCycles(4);
    // R6: bit 1 picks wordOne
    curTag = "R6"; wordOne = 12'd512; strobe(1'b1); runCycles(6);
    strobe(1'b0); runCycles(6);
    // R8: back-to-back switches keep phase
    curTag = "R8";
    for (int k = 0; k < 6; k++) strobe(k[0]);
    runCycles(3);
    // R3: wrap with large word
    curTag = "R3"; wordOne = 12'd3001; strobe(1'b1); runCycles(12);
    // R4: half-rate word
    curTag = "R4"; wordOne = 12'd2048; strobe(1'b1); runCycles(2);
    chk("R4", "antiphase", int'(evenSample), -int'(oddSample));
    runCycles(4);
    // R3: zero word holds phase
    curTag = "R3"; wordZero = 12'd0; strobe(1'b0); runCycles(2);
    chk("R3", "zero word even stable", int'(evenSample), expEven);
    runCycles(4);
    // R5 / R8: random stream
    curTag = "R5";
    for (int k = 0; k < 300; k++) begin
      wordZero = 12'($urandom); wordOne = 12'($urandom);
      symStb = ($urandom % 3) == 0; symBit = 1'($urandom);
      @(negedge clk);
    end
    symStb = 1'b0;
    // R1: reset again mid-stream
    curTag = "R1"; rst = 1'b1; wordZero = 12'd1024; runCycles(2);
    rst = 1'b0; curTag = "R2"; runCycles(3);
    curTag = "R9"; runCycles(4);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule